// File: doc/BRIEF.md
# ADC Link Training Sequencer

This block supervises the bring-up of a serial ADC receive link. After reset it asks the converter for its fixed synchronisation pattern and holds that request for a programmable number of cycles. It then starts an external input-delay calibrator and waits for its verdict. Next it pauses for a settling interval and starts an external bit-slip aligner. When the aligner reports lock, the block switches the converter to live sample output and lets received words through to the consumer.

While live, it watches a frame-error indication from the frame lane. Any frame error, and any calibrator or aligner failure, sends the link back to its first step, so the link retrains without outside help. The block only exchanges single-bit handshakes with the calibrator, the aligner and the frame checker. It never sees sample data.

Top module: `adc_link_seq`

## Requirements
- R1: While `rst_n` is low, `dly_start`, `slip_start`, `frame_err` and `word_vld` are 0 and `adc_test_pat` is 1. Reset is applied asynchronously and released through a two-stage synchroniser.
- R2: After reset release, the block stays in its pattern-request step for `INIT_HOLD` cycles. The first `dly_start` is seen `INIT_HOLD`+2 cycles after release, and `adc_test_pat` stays 1 throughout training.
- R3: `dly_start` is a one-cycle pulse in the first cycle of delay calibration. It is never high together with `slip_start`.
- R4: `dly_fail` during delay calibration returns the link to the pattern-request step. `dly_start` then pulses again `INIT_HOLD`+1 cycles after the cycle in which `dly_fail` was sampled.
- R5: `dly_lock` during delay calibration starts a settling hold of `SETTLE` cycles. `slip_start` pulses for one cycle `SETTLE`+1 cycles after the cycle in which `dly_lock` was sampled.
- R6: `slip_fail` during bit-slip calibration returns the link to the pattern-request step, and `dly_start` pulses again `INIT_HOLD`+1 cycles later.
- R7: `slip_lock` during bit-slip calibration enters live operation, and `adc_test_pat` is 0 from the next cycle.
- R8: `word_vld` equals `word_vld_in` only in live operation and is 0 in every other step.
- R9: `frame_bad` in live operation forces `word_vld` low in the same cycle. It raises `frame_err` for exactly one cycle on the next edge, sets `adc_test_pat` to 1 there, and restarts training: `dly_start` pulses `INIT_HOLD`+1 cycles after the error was sampled.
- R10: `frame_bad` outside live operation is ignored. It raises no `frame_err` and does not change the training timing.
- R11: When `dly_lock` and `dly_fail` are both high during delay calibration, the failure wins.
- R12: A lock or fail input is ignored outside the step it belongs to. For example, `slip_lock` during delay calibration and `dly_fail` during live operation have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dly_lock | input | 1 | Delay calibrator found a valid window |
| dly_fail | input | 1 | Delay calibrator found no valid setting |
| slip_lock | input | 1 | Bit-slip aligner achieved word alignment |
| slip_fail | input | 1 | Bit-slip aligner could not align |
| frame_bad | input | 1 | Frame lane word did not match its expected pattern |
| word_vld_in | input | 1 | Assembled sample word available from the datapath |
| dly_start | output | 1 | One-cycle start strobe to the delay calibrator |
| slip_start | output | 1 | One-cycle start strobe to the bit-slip aligner |
| adc_test_pat | output | 1 | 1 requests the converter's sync pattern, 0 selects live samples |
| frame_err | output | 1 | One-cycle flag on a frame error in live operation |
| word_vld | output | 1 | Gated sample-word valid to the consumer |

## Verification
The hardest situation to reach is the frame-error restart. The link must first pass a complete training sequence, with the right handshake in each step, before a frame error can mean anything. The bench drives the calibrator and aligner handshakes in response to the block's own start strobes. Along the way it walks the failure exits, including simultaneous lock and fail, and only then raises `frame_bad` in live operation. Cycle distances between strobes stand in for the internal step, which the ports do not show.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;
  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_DCAL  = 3'd1,
    ST_DWAIT = 3'd2,
    ST_SCAL  = 3'd3,
    ST_NORM  = 3'd4
  } link_state_e;
endpackage

// File: rtl/adc_link_rst_sync.sv
module adc_link_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sh_q <= '0;
    else           sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = sh_q[STAGES-1];
endmodule

// File: rtl/adc_link_timer.sv
module adc_link_timer #(
  parameter int INIT_HOLD = 8,
  parameter int SETTLE    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic init_done,
  output logic settle_done
);
  localparam int MAXC = (INIT_HOLD > SETTLE) ? INIT_HOLD : SETTLE;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] CNT_MAX   = CW'(MAXC);
  localparam logic [CW-1:0] INIT_LAST = CW'(INIT_HOLD - 1);
  localparam logic [CW-1:0] SETL_LAST = CW'(SETTLE - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = restart || (cnt_q != CNT_MAX);
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign init_done   = (cnt_q == INIT_LAST);
  assign settle_done = (cnt_q == SETL_LAST);
endmodule

// File: rtl/adc_link_fsm.sv
module adc_link_fsm
  import adc_link_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_done,
  input  logic        settle_done,
  input  logic        dly_lock,
  input  logic        dly_fail,
  input  logic        slip_lock,
  input  logic        slip_fail,
  input  logic        frame_bad,
  output link_state_e state_q,
  output link_state_e state_d
);
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT:  if (init_done) state_d = ST_DCAL;
      ST_DCAL: begin
        if (dly_fail)      state_d = ST_INIT;
        else if (dly_lock) state_d = ST_DWAIT;
      end
      ST_DWAIT: if (settle_done) state_d = ST_SCAL;
      ST_SCAL: begin
        if (slip_fail)      state_d = ST_INIT;
        else if (slip_lock) state_d = ST_NORM;
      end
      ST_NORM:  if (frame_bad) state_d = ST_INIT;
      default:  state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_INIT;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/adc_link_outputs.sv
module adc_link_outputs
  import adc_link_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  link_state_e state_q,
  input  link_state_e state_d,
  input  logic        frame_bad,
  input  logic        word_vld_in,
  output logic        dly_start,
  output logic        slip_start,
  output logic        frame_err,
  output logic        adc_test_pat,
  output logic        word_vld
);
  logic enter_dcal, enter_scal, in_norm;

  always_comb begin
    enter_dcal = (state_d == ST_DCAL) && (state_q != ST_DCAL);
    enter_scal = (state_d == ST_SCAL) && (state_q != ST_SCAL);
    in_norm    = (state_q == ST_NORM);
    word_vld   = in_norm && word_vld_in && !frame_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_start    <= 1'b0;
      slip_start   <= 1'b0;
      frame_err    <= 1'b0;
      adc_test_pat <= 1'b1;
    end else begin
      dly_start    <= enter_dcal;
      slip_start   <= enter_scal;
      frame_err    <= in_norm && frame_bad;
      adc_test_pat <= (state_d != ST_NORM);
    end
  end
endmodule

// File: rtl/adc_link_seq.sv
module adc_link_seq
  import adc_link_pkg::*;
#(
  parameter int INIT_HOLD = 8,
  parameter int SETTLE    = 6,
  parameter int SYNC_STG  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dly_lock,
  input  logic dly_fail,
  input  logic slip_lock,
  input  logic slip_fail,
  input  logic frame_bad,
  input  logic word_vld_in,
  output logic dly_start,
  output logic slip_start,
  output logic adc_test_pat,
  output logic frame_err,
  output logic word_vld
);
  logic        rst_sync_n;
  logic        init_done, settle_done, restart;
  link_state_e state_q, state_d;

  adc_link_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_in_n(rst_n), .rst_out_n(rst_sync_n)
  );

  assign restart = (state_d != state_q);

  adc_link_timer #(.INIT_HOLD(INIT_HOLD), .SETTLE(SETTLE)) u_tmr (
    .clk(clk), .rst_n(rst_sync_n), .restart(restart),
    .init_done(init_done), .settle_done(settle_done)
  );

  adc_link_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .init_done(init_done), .settle_done(settle_done),
    .dly_lock(dly_lock), .dly_fail(dly_fail),
    .slip_lock(slip_lock), .slip_fail(slip_fail),
    .frame_bad(frame_bad),
    .state_q(state_q), .state_d(state_d)
  );

  adc_link_outputs u_out (
    .clk(clk), .rst_n(rst_sync_n),
    .state_q(state_q), .state_d(state_d),
    .frame_bad(frame_bad), .word_vld_in(word_vld_in),
    .dly_start(dly_start), .slip_start(slip_start),
    .frame_err(frame_err), .adc_test_pat(adc_test_pat),
    .word_vld(word_vld)
  );
endmodule

// File: rtl/adc_link_seq_chk.sv
module adc_link_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_bad,
  input logic dly_start,
  input logic slip_start,
  input logic adc_test_pat,
  input logic frame_err,
  input logic word_vld
);
  AST_DLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dly_start |=> !dly_start);                                   // R3
  AST_START_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dly_start && slip_start));                                 // R3
  AST_SLIP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    slip_start |=> !slip_start);                                 // R5
  AST_VLD_LIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> !adc_test_pat);                                 // R8
  AST_FERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);                                   // R9
  AST_FERR_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> adc_test_pat);                                 // R9
  AST_FERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($past(frame_bad) && !$past(adc_test_pat)));   // R10
endmodule

bind adc_link_seq adc_link_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_bad(frame_bad),
  .dly_start(dly_start), .slip_start(slip_start),
  .adc_test_pat(adc_test_pat), .frame_err(frame_err), .word_vld(word_vld)
);

// File: tb/adc_link_seq_bench.sv
`timescale 1ns/1ps
module adc_link_seq_bench;
  localparam int HOLD = 8;
  localparam int SETL = 6;

  logic clk = 1'b0;
  logic rst_n, dly_lock, dly_fail, slip_lock, slip_fail, frame_bad, word_vld_in;
  logic dly_start, slip_start, adc_test_pat, frame_err, word_vld;
  int   n_pass = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #2 clk = ~clk;

  adc_link_seq #(.INIT_HOLD(HOLD), .SETTLE(SETL)) u_adc_link_seq (
    .clk(clk), .rst_n(rst_n),
    .dly_lock(dly_lock), .dly_fail(dly_fail),
    .slip_lock(slip_lock), .slip_fail(slip_fail),
    .frame_bad(frame_bad), .word_vld_in(word_vld_in),
    .dly_start(dly_start), .slip_start(slip_start),
    .adc_test_pat(adc_test_pat), .frame_err(frame_err), .word_vld(word_vld)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    if (ok) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // counts ticks until dly_start, also watching for stray frame_err and word_vld
  task automatic ticks_to_dly(output int n, output bit stray);
    n = 0; stray = 1'b0;
    for (int i = 0; i < 64; i++) begin
      tick(); n++;
      if (frame_err || word_vld || !adc_test_pat) stray = 1'b1;
      if (dly_start) return;
    end
    n = -1;
  endtask

  task automatic ticks_to_slip(output int n);
    n = 0;
    for (int i = 0; i < 64; i++) begin
      tick(); n++;
      if (dly_start) begin n = -2; return; end
      if (slip_start) return;
    end
    n = -1;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; tick(); sig = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; dly_lock = 0; dly_fail = 0; slip_lock = 0; slip_fail = 0;
    frame_bad = 1'b1; word_vld_in = 1'b1;
    repeat (3) tick();
    check(!dly_start && !slip_start && !frame_err, "R1 strobes in reset", dly_start + slip_start + frame_err, 0);
    check(adc_test_pat == 1'b1, "R1 pattern request in reset", adc_test_pat, 1);
    check(word_vld == 1'b0, "R1 word_vld in reset", word_vld, 0);
  endtask

  task automatic t_first_training();
    int n; bit stray;
    rst_n = 1'b1;
    ticks_to_dly(n, stray);
    check(n == HOLD + 2, "R2 pattern hold after reset", n, HOLD + 2);
    check(!stray, "R10 frame_bad ignored / R8 gating during training", stray, 0);
    frame_bad = 1'b0;
    tick();
    check(dly_start == 1'b0, "R3 dly_start single cycle", dly_start, 0);
  endtask

  task automatic t_dly_fail();
    int n; bit stray;
    slip_lock = 1'b1;          // R12: not in its step, must be ignored
    dly_fail  = 1'b1;
    ticks_to_dly(n, stray);
    slip_lock = 1'b0; dly_fail = 1'b0;
    check(n == HOLD + 1, "R4 R12 retrain after delay failure", n, HOLD + 1);
    tick();
  endtask

  task automatic t_lock_and_fail();
    int n; bit stray;
    dly_lock = 1'b1; dly_fail = 1'b1;
    ticks_to_dly(n, stray);
    dly_lock = 1'b0; dly_fail = 1'b0;
    check(n == HOLD + 1, "R11 failure wins over lock", n, HOLD + 1);
    tick();
  endtask

  task automatic t_settle_then_slip_fail();
    int n; bit stray;
    dly_lock = 1'b1;
    ticks_to_slip(n);
    dly_lock = 1'b0;
    check(n == SETL + 1, "R5 settle hold before slip_start", n, SETL + 1);
    tick();
    check(slip_start == 1'b0, "R5 slip_start single cycle", slip_start, 0);
    slip_fail = 1'b1;
    ticks_to_dly(n, stray);
    slip_fail = 1'b0;
    check(n == HOLD + 1, "R6 retrain after slip failure", n, HOLD + 1);
    tick();
  endtask

  task automatic t_live_and_frame_error();
    int n; bit stray;
    dly_lock = 1'b1;
    ticks_to_slip(n);
    dly_lock = 1'b0;
    check(n == SETL + 1, "R5 settle hold on retrain", n, SETL + 1);
    word_vld_in = 1'b1;
    check(word_vld == 1'b0, "R8 no word_vld before live", word_vld, 0);
    slip_lock = 1'b1; tick(); slip_lock = 1'b0;
    check(adc_test_pat == 1'b0, "R7 live samples selected", adc_test_pat, 0);
    check(word_vld == 1'b1, "R8 word_vld follows input (1)", word_vld, 1);
    word_vld_in = 1'b0; #1;
    check(word_vld == 1'b0, "R8 word_vld follows input (0)", word_vld, 0);
    word_vld_in = 1'b1;
    dly_fail = 1'b1; tick(); dly_fail = 1'b0;
    check(adc_test_pat == 1'b0 && word_vld == 1'b1, "R12 dly_fail ignored in live", adc_test_pat, 0);
    frame_bad = 1'b1; #1;
    check(word_vld == 1'b0, "R9 word_vld dropped on frame error", word_vld, 0);
    tick(); frame_bad = 1'b0;
    check(frame_err == 1'b1, "R9 frame_err raised", frame_err, 1);
    check(adc_test_pat == 1'b1, "R9 pattern requested again", adc_test_pat, 1);
    check(word_vld == 1'b0, "R9 R8 word_vld low after error", word_vld, 0);
    n = 1;
    for (int i = 0; i < 64; i++) begin
      tick(); n++;
      if (i == 0) check(frame_err == 1'b0, "R9 frame_err single cycle", frame_err, 0);
      if (dly_start) break;
    end
    check(n == HOLD + 1, "R9 retrain after frame error", n, HOLD + 1);
  endtask

  initial begin
    t_reset();
    t_first_training();
    t_dly_fail();
    t_lock_and_fail();
    t_settle_then_slip_fail();
    t_live_and_frame_error();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
      $finish;
    end
  end
endmodule